// File: doc/BRIEF.md
# Asynchronous SRAM access controller

A synchronous controller that sits between a host running on the system clock and a 16-bit static RAM with 262,144 words and no clock of its own. The host sends one request at a time. A request carries an 18-bit word address, a write flag, a 16-bit write word and a 2-bit byte mask. The controller turns it into a pin-level cycle with active-low chip enable, write enable, output enable and per-byte lane enables. Read data returns with a one-cycle valid pulse. The data bus is split into an output word, a single drive-enable and a sampled input word, so that a pad ring can build the bidirectional pins.

Every phase lasts a whole number of clock cycles. Each count is ceil(ns / clock period), with a minimum of one, and comes from parameters for the clock period and the memory's speed grade. With the defaults (4 ns clock, 12 ns access and cycle time, 8 ns write pulse, 6 ns data setup) a read holds output enable low for 3 cycles and a write holds write enable low for 2 cycles. Writes are timed by write enable, and output enable stays high for the whole write. Chip enable is high whenever the controller is idle, which keeps the memory in standby.

The state machine has seven states:
- IDLE: ready, memory deselected.
- RD_ACC: read access phase.
- RD_TURN: data valid pulse, outputs released.
- WR_SETUP: chip selected, bus driven, write enable still high.
- WR_PULSE: write enable low.
- WR_REC: write enable high, bus still driven.
- SKIP: a request with an all-zero mask.

The transitions are:
- IDLE goes to SKIP, WR_SETUP or RD_ACC on an accepted request.
- RD_ACC goes to RD_TURN when its phase count expires.
- RD_TURN goes to IDLE.
- WR_SETUP goes to WR_PULSE.
- WR_PULSE goes to WR_REC when its phase count expires.
- WR_REC goes to IDLE.
- SKIP goes to IDLE.

Top module: `asram_ctrl`

## Requirements
- R1: After reset and in every idle cycle, `host_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11 and `mem_dq_oe` is 0.
- R2: A request is accepted at a clock edge where `host_req` and `host_ready` are both 1. `host_ready` is 0 from the next cycle until the request completes. With the defaults a masked read or write keeps it low for 4 cycles, and a zero-mask request for 1 cycle.
- R3: A read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for exactly RD_CYC cycles, where RD_CYC = max(ceil(T_AA/CLK), ceil(T_RC/CLK)), 3 by default. `mem_addr` equals the request address whenever `mem_ce_n` is 0.
- R4: Read data is registered from `mem_dq_in` at the end of the access phase, with disabled lanes returned as zero. `host_rvalid` is 1 for exactly one cycle per read: the cycle after the access phase ends, or the cycle after acceptance for a zero-mask read.
- R5: Lane encoding: `host_bmask[0]` and `mem_be_n[0]` cover data bits 7:0, and bit 1 covers bits 15:8. While `mem_ce_n` is 0, `mem_be_n` equals `~host_bmask` of the request.
- R6: A write spends one setup cycle with `mem_ce_n`=0 and `mem_we_n`=1. It then holds `mem_we_n`=0 for exactly WE_CYC cycles, where WE_CYC = max(ceil(T_WP/CLK), ceil(T_DW/CLK), ceil(T_WC/CLK)-1), 2 by default. A recovery cycle follows with `mem_ce_n` and `mem_we_n` high. The enabled lanes of the word are stored when `mem_we_n` rises.
- R7: `mem_oe_n` is 1 in every cycle where `mem_we_n` is 0.
- R8: `mem_dq_oe` is 1 throughout the write-enable-low phase and in the cycle right after `mem_we_n` rises, so write data is held.
- R9: `mem_dq_oe` is never 1 while the memory drives (`mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1). Before `mem_dq_oe` rises there is at least one cycle with `mem_oe_n` high and the bus undriven.
- R10: A request with `host_bmask`=2'b00 never asserts `mem_ce_n`. A zero-mask read returns 16'h0000 with a valid pulse, and a zero-mask write leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 18 | Word address |
| host_wdata | input | 16 | Write word |
| host_bmask | input | 2 | Byte mask, bit 0 = bits 7:0 |
| host_ready | output | 1 | Controller can accept a request |
| host_rvalid | output | 1 | One-cycle read data valid |
| host_rdata | output | 16 | Read word |
| mem_addr | output | 18 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Lane enables, active low, bit 0 = bits 7:0 |
| mem_dq_out | output | 16 | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable |
| mem_dq_in | input | 16 | Sampled bus data |

## Verification
The hardest case to reach is a write issued straight after a read. This is where the controller could begin driving the bus while the memory's outputs are still on. The sweep therefore follows every write and masked read with another read, so each write after the first comes directly after a read. A pin monitor watches every cycle for overlap between bus drive and memory output, and for a missing output-enable-high gap. Zero-mask requests sit between the masked ones, so the bench also checks that they leave the stored word intact. The memory model returns a distinct filler byte on disabled lanes, so a lane that leaks through shows up as a wrong value.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_RD_TURN,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC,
        ST_SKIP
    } asram_state_e;

    // whole cycles covering a time in ns, never less than one
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_cnt.sv
module asram_phase_cnt #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES-1:0]        mask,
    input  logic                    active,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES-1:0]        be_n,
    output logic [LANES*LANE_W-1:0] din_masked
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be_n[g] = ~(active & mask[g]);
        assign din_masked[g*LANE_W +: LANE_W] =
            mask[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int LANE_W  = 8,
    parameter int CLK_NS  = 4,
    parameter int T_AA_NS = 12,
    parameter int T_RC_NS = 12,
    parameter int T_WC_NS = 12,
    parameter int T_WP_NS = 8,
    parameter int T_DW_NS = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    input  logic [DATA_W/LANE_W-1:0] host_bmask,
    output logic                     host_ready,
    output logic                     host_rvalid,
    output logic [DATA_W-1:0]        host_rdata,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic                     mem_ce_n,
    output logic                     mem_we_n,
    output logic                     mem_oe_n,
    output logic [DATA_W/LANE_W-1:0] mem_be_n,
    output logic [DATA_W-1:0]        mem_dq_out,
    output logic                     mem_dq_oe,
    input  logic [DATA_W-1:0]        mem_dq_in
);
    import asram_pkg::*;

    localparam int LANES  = DATA_W / LANE_W;
    localparam int RD_CYC = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
    localparam int WE_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                 imax(ns_to_cyc(T_WC_NS, CLK_NS) - 1, 1));
    localparam int MAXC   = imax(RD_CYC, WE_CYC);
    localparam int CW     = $clog2(MAXC + 1);

    asram_state_e st, st_nx;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, rd_masked;
    logic [LANES-1:0]  mask_q;
    logic              we_q;
    logic              accept, ph_zero, ph_load, ce_act;
    logic [CW-1:0]     ph_val;

    assign accept = host_req && (st == ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state decode
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_bmask == '0) st_nx = ST_SKIP;
                    else if (host_we)     st_nx = ST_WR_SETUP;
                    else                  st_nx = ST_RD_ACC;
                end
            end
            ST_RD_ACC:   if (ph_zero) st_nx = ST_RD_TURN;
            ST_RD_TURN:  st_nx = ST_IDLE;
            ST_WR_SETUP: st_nx = ST_WR_PULSE;
            ST_WR_PULSE: if (ph_zero) st_nx = ST_WR_REC;
            ST_WR_REC:   st_nx = ST_IDLE;
            ST_SKIP:     st_nx = ST_IDLE;
            default:     st_nx = ST_IDLE;
        endcase
    end

    // phase counter loads on entry to a timed phase
    assign ph_load = ((st_nx == ST_RD_ACC)   && (st != ST_RD_ACC)) ||
                     ((st_nx == ST_WR_PULSE) && (st != ST_WR_PULSE));
    assign ph_val  = (st_nx == ST_RD_ACC) ? CW'(RD_CYC - 1) : CW'(WE_CYC - 1);

    asram_phase_cnt #(.CW(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .zero     (ph_zero)
    );

    asram_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
        .mask       (mask_q),
        .active     (ce_act),
        .din        (mem_dq_in),
        .be_n       (mem_be_n),
        .din_masked (rd_masked)
    );

    // request and read data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            we_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= host_addr;
                wdata_q <= host_wdata;
                mask_q  <= host_bmask;
                we_q    <= host_we;
                if (host_bmask == '0 && !host_we)
                    rdata_q <= '0;
            end
            if (st == ST_RD_ACC && ph_zero)
                rdata_q <= rd_masked;
        end
    end

    // output decode
    always_comb begin
        ce_act      = 1'b0;
        mem_oe_n    = 1'b1;
        mem_we_n    = 1'b1;
        mem_dq_oe   = 1'b0;
        host_ready  = 1'b0;
        host_rvalid = 1'b0;
        unique case (st)
            ST_IDLE:     host_ready = 1'b1;
            ST_RD_ACC:   begin ce_act = 1'b1; mem_oe_n = 1'b0; end
            ST_RD_TURN:  host_rvalid = 1'b1;
            ST_WR_SETUP: begin ce_act = 1'b1; mem_dq_oe = 1'b1; end
            ST_WR_PULSE: begin ce_act = 1'b1; mem_we_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_REC:   mem_dq_oe = 1'b1;
            ST_SKIP:     host_rvalid = !we_q;
            default:     host_ready = 1'b0;
        endcase
    end

    assign mem_ce_n   = !ce_act;
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign host_rdata = rdata_q;
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic [LANES-1:0]  host_bmask,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic              mem_dq_oe
);
    p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

    p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready) |=> !host_ready);

    p_addr_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |=> !host_rvalid);

    p_oe_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_data_during_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> mem_dq_oe);

    p_no_contention_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n || mem_ce_n || !mem_we_n));

    p_turnaround_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && host_bmask == '0) |=> mem_ce_n);
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W / LANE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_bmask  (host_bmask),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .mem_addr    (mem_addr),
    .mem_ce_n    (mem_ce_n),
    .mem_we_n    (mem_we_n),
    .mem_oe_n    (mem_oe_n),
    .mem_be_n    (mem_be_n),
    .mem_dq_oe   (mem_dq_oe)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;
    localparam int CLK_NS = 4;
    // phase lengths from the requirement formulas
    localparam int RD_CYC = (12 + CLK_NS - 1) / CLK_NS;
    localparam int WE_CYC = (8 + CLK_NS - 1) / CLK_NS;
    localparam int BUSY   = RD_CYC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [17:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [1:0]  host_bmask = '0;
    logic        host_ready, host_rvalid;
    logic [15:0] host_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    asram_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_bmask(host_bmask),
        .host_ready(host_ready), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [17:0] a);
        return a[15:0] ^ {a[17:16], 14'h15A5};
    endfunction

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // memory model: the device on the pins
    logic [15:0] mem_m [int];
    logic [15:0] ref_m [int];

    function automatic logic [15:0] mem_rd(input logic [17:0] a);
        return mem_m.exists(int'(a)) ? mem_m[int'(a)] : init_word(a);
    endfunction
    function automatic logic [15:0] ref_rd(input logic [17:0] a);
        return ref_m.exists(int'(a)) ? ref_m[int'(a)] : init_word(a);
    endfunction

    bit          pend = 1'b0;
    logic [17:0] pend_a;
    logic [15:0] pend_d;
    logic [1:0]  pend_l;
    logic        prev_we_n = 1'b1, prev_dq_oe = 1'b0;
    int          gap = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pend && mem_we_n) begin
                logic [15:0] w;
                w = mem_rd(pend_a);
                w = (w & ~lane_bits(pend_l)) | (pend_d & lane_bits(pend_l));
                mem_m[int'(pend_a)] = w;
                pend = 1'b0;
            end
            if (!mem_ce_n && !mem_we_n) begin
                pend   = 1'b1;
                pend_a = mem_addr;
                pend_d = mem_dq_out;
                pend_l = ~mem_be_n;
                chk(mem_dq_oe, "R8 drive while WE low", {31'd0, mem_dq_oe}, 1);
                chk(mem_oe_n, "R7 OE high in write", {31'd0, mem_oe_n}, 1);
            end
            if (!prev_we_n && mem_we_n)
                chk(mem_dq_oe, "R8 hold after WE rise", {31'd0, mem_dq_oe}, 1);
            if (mem_dq_oe && !mem_ce_n && !mem_oe_n && mem_we_n)
                chk(1'b0, "R9 bus contention", 1, 0);
            if (mem_dq_oe && !prev_dq_oe)
                chk(gap >= 1, "R9 turnaround gap", gap, 1);
            if (!mem_oe_n) gap = 0;
            else if (!mem_dq_oe) gap++;
            prev_we_n  = mem_we_n;
            prev_dq_oe = mem_dq_oe;
        end
        if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in = (mem_rd(mem_addr) & ~{{8{mem_be_n[1]}}, {8{mem_be_n[0]}}}) |
                        (16'hEEEE & {{8{mem_be_n[1]}}, {8{mem_be_n[0]}}});
        else
            mem_dq_in = 16'hEEEE;
    end

    task automatic idle_pins(input string tag);
        chk(host_ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && mem_be_n == 2'b11,
            tag, {26'd0, host_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, &mem_be_n},
            32'h3D);
    endtask

    task automatic xact(input bit w, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int busy = 0, ce_lo = 0, oe_lo = 0, we_lo = 0, rv = 0;
        bit addr_bad = 0, be_bad = 0;
        logic [15:0] rd = '0;
        logic [15:0] exp;
        @(negedge clk);
        host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d; host_bmask = m;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            host_req = 1'b0;
            if (host_ready) break;
            busy++;
            if (!mem_ce_n) begin
                ce_lo++;
                if (mem_addr != a) addr_bad = 1;
                if (mem_be_n != ~m) be_bad = 1;
            end
            if (!mem_oe_n) oe_lo++;
            if (!mem_we_n) we_lo++;
            if (host_rvalid) begin rv++; rd = host_rdata; end
        end
        chk(busy == ((m == 0) ? 1 : BUSY), "R2 busy cycles", busy, (m == 0) ? 1 : BUSY);
        idle_pins("R1 idle after request");
        if (m == 0) begin
            chk(ce_lo == 0, "R10 no chip enable", ce_lo, 0);
            if (!w) begin
                chk(rv == 1, "R10 zero-mask valid", rv, 1);
                chk(rd == 16'h0, "R10 zero-mask data", rd, 0);
            end
        end else begin
            chk(!addr_bad, "R3 address while selected", 32'(addr_bad), 0);
            chk(!be_bad, "R5 lane enables", 32'(be_bad), 0);
            if (w) begin
                chk(we_lo == WE_CYC, "R6 write pulse cycles", we_lo, WE_CYC);
                chk(ce_lo == WE_CYC + 1, "R6 write select cycles", ce_lo, WE_CYC + 1);
                chk(oe_lo == 0, "R7 no OE in write", oe_lo, 0);
                ref_m[int'(a)] = (ref_rd(a) & ~lane_bits(m)) | (d & lane_bits(m));
            end else begin
                chk(oe_lo == RD_CYC && ce_lo == RD_CYC, "R3 read access cycles", oe_lo, RD_CYC);
                chk(rv == 1, "R4 valid pulse count", rv, 1);
                exp = ref_rd(a) & lane_bits(m);
                chk(rd == exp, "R4 R5 read data", rd, exp);
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_pins("R1 reset state");
        chk(!host_rvalid, "R4 no valid at reset", {31'd0, host_rvalid}, 0);
        for (int i = 0; i < 24; i++) begin
            logic [17:0] a;
            case (i)
                0: a = 18'h00000;
                1: a = 18'h3FFFF;
                2: a = 18'h20000;
                3: a = 18'h00001;
                default: a = 18'(i * 10007 + 12345);
            endcase
            for (int m = 0; m < 4; m++) begin
                xact(1'b1, a, 16'(a * 3 + m * 16'h1111 + 16'h0F0F), 2'(m));
                xact(1'b0, a, 16'h0, 2'(m));
                xact(1'b0, a, 16'h0, 2'b11);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule